// File: doc/BRIEF.md
# Load Post-Speculation Validate/Expose Issuer

This block sits beside a circular load queue and, once a load has been speculatively executed and is cleared to become visible, sends it one or two post-speculation memory packets. Each packet is either a validate, which the memory side answers with a check byte per cache line, or an expose, which needs no answer. The kind of each packet comes from the load's L1-hit flags and an expose-only flag. A load whose access crosses a line boundary sends a low-line packet and then a high-line packet. A validate answer whose validated half carries a zero check byte marks the load for re-execution.

A registered pending counter holds the number of loads that are armed and not yet sent. The scan runs only while that counter is non-zero. Every cycle the scan starts again from the queue head, because loads can become ready in any order. It handles at most one load per cycle. An entry is reported ready for commit once it is executed and its post-speculation work is complete. A one-cycle squash mask and a one-cycle allocate mask manage the entry state.

Top module: `load_expose_issuer`

## Requirements
- R1: An entry is armed when `need_post`, `ready_exp` and queue membership (circular offset from `lq_head` below `lq_count`) all hold. No request is ever made for an entry that is unarmed or outside the queue.
- R2: The load handled in a cycle is the first armed, unsent, unsquashed entry in circular order from `lq_head`. Each load is requested only until it is recorded as sent.
- R3: An armed entry with `faulted` set is consumed without any packet, one cycle after its arming edge. It is marked complete, so it is commit-ready once `executed` is high, and `reexec` stays 0.
- R4: A single-line load sends one packet with `req_high`=0. The packet is an expose (`req_validate`=0) if `expose_only` or `l1hit_lo` is set, and a validate (`req_validate`=1) otherwise.
- R5: A split load sends its low packet (`req_high`=0) and then, in the next cycle, its high packet (`req_high`=1). Each half is an expose if `expose_only` or that half's L1-hit flag is set, and a validate otherwise.
- R6: A refused low packet records nothing and is offered again. A refused high packet leaves the load unsent, and the load starts over from its low packet.
- R7: A load whose packets are all exposes is complete as soon as its last packet is accepted.
- R8: A load that sent any validate stays incomplete until a response. The response sets `reexec` when a validated half has a check byte of 0x00; otherwise the load completes with `reexec`=0.
- R9: A response for an entry that is already complete or squashed changes nothing.
- R10: A squashed entry is never requested and never commit-ready until it is allocated again.
- R11: `cnt_validate` counts loads sent with at least one validate. `cnt_expose` counts loads sent with only exposes. `cnt_converted` counts sent loads that had `expose_only` set.
- R12: An `alloc` pulse clears all state of an entry, and the entry may then be armed and requested again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lq_head | input | IW | Index of the oldest queue entry |
| lq_count | input | IW+1 | Number of occupied entries |
| alloc | input | DEPTH | One-cycle pulse that clears an entry's state |
| need_post | input | DEPTH | Entry needs post-speculation work |
| ready_exp | input | DEPTH | Entry is cleared to become visible |
| faulted | input | DEPTH | Entry carries a fault |
| executed | input | DEPTH | Entry has finished execution |
| expose_only | input | DEPTH | Entry needs exposes only |
| split | input | DEPTH | Entry spans two lines |
| l1hit_lo | input | DEPTH | Low line hit in L1 |
| l1hit_hi | input | DEPTH | High line hit in L1 |
| squash_mask | input | DEPTH | One-cycle squash of entries |
| req_valid | output | 1 | Packet offered |
| req_ready | input | 1 | Memory side accepts the packet |
| req_idx | output | IW | Queue entry of the packet |
| req_high | output | 1 | 1 = high-line packet |
| req_validate | output | 1 | 1 = validate, 0 = expose |
| rsp_valid | input | 1 | Validate response present |
| rsp_idx | input | IW | Entry of the response |
| rsp_chk_lo | input | 8 | Check byte of the low line |
| rsp_chk_hi | input | 8 | Check byte of the high line |
| commit_rdy | output | DEPTH | Entry executed and complete |
| reexec | output | DEPTH | Entry failed validation |
| cnt_validate | output | CW | Loads sent with a validate |
| cnt_expose | output | CW | Loads sent with exposes only |
| cnt_converted | output | CW | Sent loads with the expose-only flag set |

## Verification
If the pending counter drifts from the set of armed, unsent entries, the scan either stalls with loads still waiting or runs when nothing is armed. A stall shows as `req_valid` staying low one cycle after arming; a spurious run shows as a request for an unarmed entry in that same cycle. If the per-entry completion or sent bits are wrong, the fault shows within one cycle as a repeated request, a missing or early `commit_rdy`, or a `reexec` with no response behind it. If the half-phase state is wrong, the next cycle shows a high packet that no accepted low packet preceded, or a low packet that is never re-offered after a refusal.

// File: rtl/load_expose_issuer.sv
module load_expose_issuer #(
  parameter int DEPTH = 16,
  parameter int CW = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int PW = IW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IW-1:0]    lq_head,
  input  logic [IW:0]      lq_count,
  input  logic [DEPTH-1:0] alloc,
  input  logic [DEPTH-1:0] need_post,
  input  logic [DEPTH-1:0] ready_exp,
  input  logic [DEPTH-1:0] faulted,
  input  logic [DEPTH-1:0] executed,
  input  logic [DEPTH-1:0] expose_only,
  input  logic [DEPTH-1:0] split,
  input  logic [DEPTH-1:0] l1hit_lo,
  input  logic [DEPTH-1:0] l1hit_hi,
  input  logic [DEPTH-1:0] squash_mask,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [IW-1:0]    req_idx,
  output logic             req_high,
  output logic             req_validate,
  input  logic             rsp_valid,
  input  logic [IW-1:0]    rsp_idx,
  input  logic [7:0]       rsp_chk_lo,
  input  logic [7:0]       rsp_chk_hi,
  output logic [DEPTH-1:0] commit_rdy,
  output logic [DEPTH-1:0] reexec,
  output logic [CW-1:0]    cnt_validate,
  output logic [CW-1:0]    cnt_expose,
  output logic [CW-1:0]    cnt_converted
);

  logic [DEPTH-1:0] armed, sent, done, sq, rx;
  logic [PW-1:0]    pend;
  logic             hi_phase;
  logic [IW-1:0]    hold_idx;

  logic [DEPTH-1:0] in_q, kill, elig, newarm;
  logic             found;
  logic [IW-1:0]    pick, cur;

  assign kill = squash_mask | alloc;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      in_q[i] = {1'b0, IW'(i) - lq_head} < lq_count;
  end

  assign elig   = armed & ~sent & ~sq & in_q & ~kill;
  assign newarm = need_post & ready_exp & in_q & ~armed & ~sent & ~sq & ~kill;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (!found && pend != '0 && elig[lq_head + IW'(k)]) begin
        found = 1'b1;
        pick  = lq_head + IW'(k);
      end
    end
  end

  assign cur = hi_phase ? hold_idx : pick;

  wire lo_v    = !expose_only[cur] && !l1hit_lo[cur];
  wire hi_v    = !expose_only[cur] && !l1hit_hi[cur];
  wire all_exp = !lo_v && (!split[cur] || !hi_v);

  wire hi_ok      = hi_phase && elig[hold_idx];
  wire lo_go      = !hi_phase && found && !faulted[pick];
  wire fault_take = !hi_phase && found && faulted[pick];
  wire rec        = (hi_ok && req_ready) || (lo_go && req_ready && !split[pick]);
  wire take       = rec || fault_take;

  assign req_valid    = hi_ok || lo_go;
  assign req_idx      = cur;
  assign req_high     = hi_phase;
  assign req_validate = hi_phase ? hi_v : lo_v;

  wire rv_lo    = !expose_only[rsp_idx] && !l1hit_lo[rsp_idx];
  wire rv_hi    = split[rsp_idx] && !expose_only[rsp_idx] && !l1hit_hi[rsp_idx];
  wire rsp_fail = (rv_lo && rsp_chk_lo == 8'h00) || (rv_hi && rsp_chk_hi == 8'h00);
  wire rsp_ok   = rsp_valid && sent[rsp_idx] && !done[rsp_idx] && !sq[rsp_idx] && !kill[rsp_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= '0; sent <= '0; done <= '0; sq <= '0; rx <= '0;
      pend <= '0; hi_phase <= 1'b0; hold_idx <= '0;
      cnt_validate <= '0; cnt_expose <= '0; cnt_converted <= '0;
    end else begin
      pend <= pend + PW'($countones(newarm)) - PW'($countones(kill & armed & ~sent))
                   - PW'(take);
      hi_phase <= lo_go && req_ready && split[pick];
      if (lo_go && req_ready && split[pick]) hold_idx <= pick;
      if (rec) begin
        if (all_exp) cnt_expose <= cnt_expose + 1'b1;
        else         cnt_validate <= cnt_validate + 1'b1;
        if (expose_only[cur]) cnt_converted <= cnt_converted + 1'b1;
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc[i]) begin
          armed[i] <= 1'b0; sent[i] <= 1'b0; done[i] <= 1'b0;
          sq[i] <= 1'b0; rx[i] <= 1'b0;
        end else begin
          if (squash_mask[i]) begin
            sq[i] <= 1'b1;
            armed[i] <= 1'b0;
          end else if (newarm[i]) begin
            armed[i] <= 1'b1;
          end
          if (take && cur == IW'(i)) begin
            sent[i] <= 1'b1;
            if (fault_take || all_exp) done[i] <= 1'b1;
          end
          if (rsp_ok && rsp_idx == IW'(i)) begin
            done[i] <= 1'b1;
            rx[i]   <= rsp_fail;
          end
        end
      end
    end
  end

  assign commit_rdy = executed & done & ~sq;
  assign reexec     = rx;

  assert_pend_tracks_armed_R1: assert property (@(posedge clk) disable iff (rst)
    pend == PW'($countones(armed & ~sent)));

  assert_req_only_armed_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (armed[req_idx] && !sent[req_idx] && !sq[req_idx]));

  assert_high_after_low_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_high) |-> $past(req_valid && req_ready && !req_high));

  assert_done_implies_sent_R7: assert property (@(posedge clk) disable iff (rst)
    (done & ~sent) == '0);

  assert_reexec_from_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    ((rx & ~$past(rx)) != '0) |-> $past(rsp_valid));

endmodule

// File: tb/load_expose_issuer_test.sv
module load_expose_issuer_test;
  localparam int DEPTH = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst;
  logic [IW-1:0] lq_head;
  logic [IW:0] lq_count;
  logic [DEPTH-1:0] alloc, need_post, ready_exp, faulted, executed, expose_only;
  logic [DEPTH-1:0] split, l1hit_lo, l1hit_hi, squash_mask;
  logic req_valid, req_ready, req_high, req_validate;
  logic [IW-1:0] req_idx;
  logic rsp_valid;
  logic [IW-1:0] rsp_idx;
  logic [7:0] rsp_chk_lo, rsp_chk_hi;
  logic [DEPTH-1:0] commit_rdy, reexec;
  logic [15:0] cnt_validate, cnt_expose, cnt_converted;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  load_expose_issuer uut (
    .clk(clk), .rst(rst), .lq_head(lq_head), .lq_count(lq_count), .alloc(alloc),
    .need_post(need_post), .ready_exp(ready_exp), .faulted(faulted), .executed(executed),
    .expose_only(expose_only), .split(split), .l1hit_lo(l1hit_lo), .l1hit_hi(l1hit_hi),
    .squash_mask(squash_mask), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .req_high(req_high), .req_validate(req_validate),
    .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_chk_lo(rsp_chk_lo),
    .rsp_chk_hi(rsp_chk_hi), .commit_rdy(commit_rdy), .reexec(reexec),
    .cnt_validate(cnt_validate), .cnt_expose(cnt_expose), .cnt_converted(cnt_converted)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic start(input logic [IW-1:0] head, input logic [IW:0] count);
    rst = 1'b1;
    alloc = '0; need_post = '0; ready_exp = '0; faulted = '0; executed = '0;
    expose_only = '0; split = '0; l1hit_lo = '0; l1hit_hi = '0; squash_mask = '0;
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_idx = '0; rsp_chk_lo = '0; rsp_chk_hi = '0;
    lq_head = head; lq_count = count;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic respond(input logic [IW-1:0] idx, input logic [7:0] lo, input logic [7:0] hi);
    rsp_valid = 1'b1; rsp_idx = idx; rsp_chk_lo = lo; rsp_chk_hi = hi;
    step();
    rsp_valid = 1'b0;
  endtask

  task automatic test_reset();
    start(0, 4);
    check("R1 reset req_valid", req_valid, 0);
    check("R1 reset commit_rdy", commit_rdy, 0);
    check("R8 reset reexec", reexec, 0);
    check("R11 reset counters", {cnt_validate, cnt_expose}, 0);
  endtask

  task automatic test_single_validate();
    start(0, 1);
    need_post[0] = 1'b1;
    step(); step();
    check("R1 not ready no request", req_valid, 0);
    ready_exp[0] = 1'b1;
    step();
    check("R4 request offered", req_valid, 1);
    check("R4 index", req_idx, 0);
    check("R4 low half", req_high, 0);
    check("R4 validate kind", req_validate, 1);
    req_ready = 1'b1; executed[0] = 1'b1;
    step();
    check("R2 sent once", req_valid, 0);
    check("R8 waits for response", commit_rdy[0], 0);
    respond(0, 8'h01, 8'h00);
    check("R8 pass commit", commit_rdy[0], 1);
    check("R8 pass no reexec", reexec[0], 0);
    check("R11 validate count", cnt_validate, 1);
    check("R11 expose count", cnt_expose, 0);
  endtask

  task automatic test_validate_fail();
    start(0, 4);
    need_post[3] = 1'b1; ready_exp[3] = 1'b1; executed[3] = 1'b1; req_ready = 1'b1;
    step();
    check("R2 picks entry 3", req_idx, 3);
    step();
    respond(3, 8'h00, 8'h55);
    check("R8 zero byte reexec", reexec[3], 1);
    check("R8 completes after fail", commit_rdy[3], 1);
    respond(3, 8'h09, 8'h09);
    check("R9 late response ignored", reexec[3], 1);
  endtask

  task automatic test_expose_hit();
    start(0, 2);
    need_post[1] = 1'b1; ready_exp[1] = 1'b1; l1hit_lo[1] = 1'b1; executed[1] = 1'b1;
    req_ready = 1'b1;
    step();
    check("R4 l1 hit gives expose", req_validate, 0);
    step();
    check("R7 expose completes at once", commit_rdy[1], 1);
    check("R11 expose count", cnt_expose, 1);
    check("R11 validate count unchanged", cnt_validate, 0);
    respond(1, 8'h00, 8'h00);
    check("R9 response to completed ignored", reexec[1], 0);
  endtask

  task automatic test_split_expose_only();
    start(0, 4);
    need_post[2] = 1'b1; ready_exp[2] = 1'b1; split[2] = 1'b1; expose_only[2] = 1'b1;
    executed[2] = 1'b1; req_ready = 1'b1;
    step();
    check("R5 low half first", req_high, 0);
    check("R5 low expose", req_validate, 0);
    step();
    check("R5 high half next", {req_valid, req_high}, 2'b11);
    check("R5 high expose", req_validate, 0);
    step();
    check("R7 no more packets", req_valid, 0);
    check("R7 all-expose split completes", commit_rdy[2], 1);
    check("R11 converted count", cnt_converted, 1);
    check("R11 expose count split", cnt_expose, 1);
  endtask

  task automatic test_split_mixed();
    start(0, 8);
    need_post[6] = 1'b1; ready_exp[6] = 1'b1; split[6] = 1'b1; l1hit_lo[6] = 1'b1;
    executed[6] = 1'b1; req_ready = 1'b1;
    step();
    check("R5 low idx", req_idx, 6);
    check("R5 low kind expose", {req_high, req_validate}, 2'b00);
    step();
    check("R5 high kind validate", {req_valid, req_high, req_validate}, 3'b111);
    step();
    check("R8 split waits", commit_rdy[6], 0);
    respond(6, 8'h00, 8'h07);
    check("R8 exposed half byte ignored", reexec[6], 0);
    check("R8 split completes", commit_rdy[6], 1);
  endtask

  task automatic test_backpressure();
    start(0, 8);
    need_post[0] = 1'b1; ready_exp[0] = 1'b1;
    step(); step(); step();
    check("R6 refused low still offered", {req_valid, req_idx}, {1'b1, 4'd0});
    check("R6 nothing recorded", cnt_validate, 0);
    req_ready = 1'b1;
    step();
    check("R6 accepted", req_valid, 0);
    check("R6 recorded once", cnt_validate, 1);
    need_post[4] = 1'b1; ready_exp[4] = 1'b1; split[4] = 1'b1;
    step();
    check("R6 split low", {req_idx, req_high}, {4'd4, 1'b0});
    step();
    check("R6 split high", req_high, 1);
    req_ready = 1'b0;
    step();
    check("R6 restart from low", {req_valid, req_idx, req_high}, {1'b1, 4'd4, 1'b0});
    check("R6 refused high unsent", cnt_validate, 1);
    req_ready = 1'b1;
    step();
    check("R6 high again", req_high, 1);
    step();
    check("R6 split recorded", {req_valid, cnt_validate}, {1'b0, 16'd2});
  endtask

  task automatic test_order();
    start(12, 8);
    need_post[14] = 1'b1; need_post[1] = 1'b1; need_post[9] = 1'b1;
    ready_exp = need_post; l1hit_lo = need_post; req_ready = 1'b1;
    step();
    check("R2 head side first", req_idx, 14);
    step();
    check("R2 wrapped entry next", {req_valid, req_idx}, {1'b1, 4'd1});
    step();
    check("R1 outside queue never requested", req_valid, 0);
  endtask

  task automatic test_fault();
    start(0, 8);
    need_post[5] = 1'b1; ready_exp[5] = 1'b1; faulted[5] = 1'b1; executed[5] = 1'b1;
    need_post[7] = 1'b1; ready_exp[7] = 1'b1; req_ready = 1'b1;
    step();
    check("R3 fault sends no packet", req_valid, 0);
    step();
    check("R3 fault commit", commit_rdy[5], 1);
    check("R3 fault no reexec", reexec[5], 0);
    check("R2 next entry after fault", {req_valid, req_idx}, {1'b1, 4'd7});
    check("R3 fault not counted", cnt_validate + cnt_expose, 0);
  endtask

  task automatic test_squash();
    start(0, 4);
    need_post[2] = 1'b1; squash_mask[2] = 1'b1;
    step();
    squash_mask = '0; ready_exp[2] = 1'b1; executed[2] = 1'b1;
    step(); step();
    check("R10 squashed never requested", req_valid, 0);
    check("R10 squashed not commit", commit_rdy[2], 0);
    need_post[3] = 1'b1; ready_exp[3] = 1'b1; executed[3] = 1'b1; req_ready = 1'b1;
    step();
    check("R10 live entry requested", req_idx, 3);
    step();
    squash_mask[3] = 1'b1;
    step();
    squash_mask = '0;
    respond(3, 8'h01, 8'h01);
    check("R9 response to squashed ignored", commit_rdy[3], 0);
    check("R9 squashed no reexec", reexec[3], 0);
  endtask

  task automatic test_alloc();
    start(0, 2);
    need_post[1] = 1'b1; ready_exp[1] = 1'b1; l1hit_lo[1] = 1'b1; executed[1] = 1'b1;
    req_ready = 1'b1;
    step(); step();
    check("R12 complete before alloc", commit_rdy[1], 1);
    alloc[1] = 1'b1;
    step();
    alloc = '0;
    check("R12 alloc clears completion", commit_rdy[1], 0);
    check("R12 no request in alloc cycle", req_valid, 0);
    step();
    check("R12 entry requested again", {req_valid, req_idx}, {1'b1, 4'd1});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_single_validate();
    test_validate_fail();
    test_expose_hit();
    test_split_expose_only();
    test_split_mixed();
    test_backpressure();
    test_order();
    test_fault();
    test_squash();
    test_alloc();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule